// File: doc/BRIEF.md
# Horizontal Line Clip Unit

This unit sits in a pixel stream between a line-fetch stage and a compositor. Each incoming line carries the full programmed source width. The unit forwards only a contiguous window of columns and drops a programmed number of pixels at the left and right of every line. Every line of the frame is kept, because only the width is clipped. A bypass setting forwards whole lines unchanged.

Configuration arrives on static inputs and is copied into an active set at frame boundaries only, so one frame is never processed with mixed settings. A reload-disable input holds the active set at a boundary. The source width and the input height are packed into one size word as value minus one: width in the upper half, height in the lower half. A clip word carries the left drop count in its upper half and the right count in its lower half. The right count is encoded as source width minus (window start plus window width) minus one.

Control is a two-state machine. BOUNDARY is entered from reset and after the pixel marked end-of-frame is accepted. In BOUNDARY the active configuration is loaded (unless reload is disabled), no pixel is accepted, and the machine always moves to STREAM on the next cycle. STREAM stays in STREAM until a pixel marked end-of-frame is accepted, and then returns to BOUNDARY. Pixels move through combinationally: a kept pixel is offered downstream in the same cycle, and a dropped pixel is consumed without waiting for downstream.

Top module: `hline_clip`

## Requirements
- R1: While reset is asserted, `in_ready` and `out_valid` are low.
- R2: With bypass clear, a line of source width W forwards exactly the columns from the left count L up to its last window column, in order and with data unchanged. All other columns are dropped.
- R3: The last forwarded column is (W-1) - right - 1, computed modulo 2^COORD_W. A right count of all ones therefore lets the window reach column W-1.
- R4: With the bypass setting active, every pixel of every line is forwarded and the clip word is ignored.
- R5: `out_sol` is high only on the first forwarded pixel of a line, and `out_eol` only on the last forwarded pixel of a line.
- R6: `out_eof` is high on the last forwarded pixel of line H-1, where H-1 is the lower half of the size word. Every line 0..H-1 produces forwarded pixels.
- R7: The active configuration changes only in the BOUNDARY state. Changes to the configuration inputs during STREAM have no effect on the frame in progress.
- R8: If `cfg_reload_dis` is high in the BOUNDARY cycle, the previous active configuration is kept for the next frame.
- R9: While a kept pixel is offered (`out_valid` high), `in_ready` equals `out_ready`. A dropped pixel is accepted whatever `out_ready` is.
- R10: After reset and after each accepted end-of-frame pixel, `in_ready` is low for exactly one cycle (BOUNDARY) before STREAM resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bypass | input | 1 | Forward whole lines when set |
| cfg_reload_dis | input | 1 | Hold the active configuration at the frame boundary |
| cfg_size | input | 2*COORD_W | Upper half: source width-1; lower half: height-1 |
| cfg_clip | input | 2*COORD_W | Upper half: left count; lower half: encoded right count |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_data | input | PIX_W | Input pixel value |
| in_sol | input | 1 | Input pixel is column 0 of a line |
| in_eof | input | 1 | Input pixel is the last of the frame |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts output pixel |
| out_data | output | PIX_W | Output pixel value |
| out_sol | output | 1 | First forwarded pixel of a line |
| out_eol | output | 1 | Last forwarded pixel of a line |
| out_eof | output | 1 | Last forwarded pixel of the frame |

## Verification
The assertions assume a well-formed input stream. `in_sol` is asserted only on column 0 of each line, every line is exactly the active source width long, and `in_eof` is asserted only on the final column of line H-1 of the active geometry. In a non-bypass setting they also assume the window is not empty. The stimulus builds every frame from the geometry the bench model holds as active, including frames sent with reload disabled. It picks the window start and width so that the window always lies inside the line, and it changes configuration inputs mid-frame only after at least one full line, never on the final line.

// File: rtl/hlc_pkg.sv
`timescale 1ns/1ps
package hlc_pkg;

    typedef enum logic [0:0] {
        ST_BOUNDARY = 1'b0,
        ST_STREAM   = 1'b1
    } hlc_state_e;

    typedef struct packed {
        logic first;
        logic last;
        logic frame_last;
    } hlc_mark_t;

endpackage

// File: rtl/hlc_ctrl_fsm.sv
`timescale 1ns/1ps
module hlc_ctrl_fsm
    import hlc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic frame_done,
    output logic stream_en,
    output logic load_en
);

    hlc_state_e state_q;
    hlc_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_BOUNDARY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOUNDARY: state_d = ST_STREAM;
            ST_STREAM:   if (frame_done) state_d = ST_BOUNDARY;
            default:     state_d = ST_BOUNDARY;
        endcase
    end

    always_comb begin
        stream_en = 1'b0;
        load_en   = 1'b0;
        unique case (state_q)
            ST_BOUNDARY: load_en   = 1'b1;
            ST_STREAM:   stream_en = 1'b1;
            default:     load_en   = 1'b0;
        endcase
    end

    // R10: the boundary state lasts exactly one cycle
    p_boundary_single_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BOUNDARY) |=> (state_q == ST_STREAM));

    // R7: streaming continues until an end-of-frame pixel is taken
    p_hold_stream_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STREAM && !frame_done) |=> (state_q == ST_STREAM));

    // R10: accepted end-of-frame always leads to the boundary
    p_eof_to_boundary_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STREAM && frame_done) |=> (state_q == ST_BOUNDARY));

endmodule

// File: rtl/hlc_shadow_cfg.sv
`timescale 1ns/1ps
module hlc_shadow_cfg #(
    parameter int COORD_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_en,
    input  logic                 reload_dis,
    input  logic                 bypass_in,
    input  logic [2*COORD_W-1:0] size_in,
    input  logic [2*COORD_W-1:0] clip_in,
    output logic                 act_bypass,
    output logic [COORD_W-1:0]   act_width_m1,
    output logic [COORD_W-1:0]   act_height_m1,
    output logic [COORD_W-1:0]   act_left,
    output logic [COORD_W-1:0]   act_right
);

    localparam int HI = 2 * COORD_W - 1;
    localparam int LO = COORD_W - 1;

    logic take;
    assign take = load_en && !reload_dis;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_bypass    <= 1'b1;
            act_width_m1  <= '0;
            act_height_m1 <= '0;
            act_left      <= '0;
            act_right     <= '0;
        end else if (take) begin
            act_bypass    <= bypass_in;
            act_width_m1  <= size_in[HI:COORD_W];
            act_height_m1 <= size_in[LO:0];
            act_left      <= clip_in[HI:COORD_W];
            act_right     <= clip_in[LO:0];
        end
    end

    logic [4*COORD_W:0] act_all;
    assign act_all = {act_bypass, act_width_m1, act_height_m1, act_left, act_right};

    // R7: active set frozen outside the boundary state
    p_frozen_outside_boundary_r7: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $stable(act_all));

    // R8: reload disabled at the boundary keeps the previous set
    p_reload_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (load_en && reload_dis) |=> $stable(act_all));

    // R7: an enabled boundary copies the programmed width
    p_reload_take_r7: assert property (@(posedge clk) disable iff (rst)
        (load_en && !reload_dis) |=> (act_width_m1 == $past(size_in[HI:COORD_W])));

endmodule

// File: rtl/hlc_col_track.sv
`timescale 1ns/1ps
module hlc_col_track
    import hlc_pkg::*;
#(
    parameter int COORD_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               fire,
    input  logic               in_sol,
    input  logic               in_eof,
    input  logic               act_bypass,
    input  logic [COORD_W-1:0] act_width_m1,
    input  logic [COORD_W-1:0] act_height_m1,
    input  logic [COORD_W-1:0] act_left,
    input  logic [COORD_W-1:0] act_right,
    output logic               keep,
    output hlc_mark_t          mark
);

    localparam logic [COORD_W-1:0] ONE = COORD_W'(1);

    logic [COORD_W-1:0] col_q;
    logic [COORD_W-1:0] line_q;
    logic [COORD_W-1:0] cur_col;
    logic [COORD_W-1:0] last_col;
    logic               line_end;

    assign cur_col  = in_sol ? '0 : col_q;
    // modular: an all-ones right count reaches the final column
    assign last_col = act_width_m1 - act_right - ONE;
    assign line_end = (cur_col == act_width_m1);

    always_comb begin
        if (act_bypass) begin
            keep       = 1'b1;
            mark.first = (cur_col == '0);
            mark.last  = line_end;
        end else begin
            keep       = (cur_col >= act_left) && (cur_col <= last_col);
            mark.first = (cur_col == act_left);
            mark.last  = (cur_col == last_col);
        end
        mark.frame_last = (line_q == act_height_m1);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            col_q  <= '0;
            line_q <= '0;
        end else if (fire) begin
            if (line_end) begin
                col_q  <= '0;
                line_q <= line_q + ONE;
            end else begin
                col_q  <= cur_col + ONE;
            end
        end
    end

    // R5: input assumption, start-of-line only at column 0
    p_sol_at_col0_r5: assert property (@(posedge clk) disable iff (rst)
        (fire && in_sol) |-> (col_q == '0));

    // R6: input assumption, end-of-frame only at the last column of the last line
    p_eof_at_end_r6: assert property (@(posedge clk) disable iff (rst)
        (fire && in_eof) |-> (line_end && line_q == act_height_m1));

    // R2: column counter stays inside the source line
    p_col_range_r2: assert property (@(posedge clk) disable iff (rst)
        !clear |-> (col_q <= act_width_m1));

    // R6: lines never run past the programmed height
    p_line_range_r6: assert property (@(posedge clk) disable iff (rst)
        !clear |-> (line_q <= act_height_m1));

endmodule

// File: rtl/hline_clip.sv
`timescale 1ns/1ps
module hline_clip
    import hlc_pkg::*;
#(
    parameter int PIX_W   = 24,
    parameter int COORD_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_bypass,
    input  logic                 cfg_reload_dis,
    input  logic [2*COORD_W-1:0] cfg_size,
    input  logic [2*COORD_W-1:0] cfg_clip,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [PIX_W-1:0]     in_data,
    input  logic                 in_sol,
    input  logic                 in_eof,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [PIX_W-1:0]     out_data,
    output logic                 out_sol,
    output logic                 out_eol,
    output logic                 out_eof
);

    logic               stream_en;
    logic               load_en;
    logic               fire;
    logic               frame_done;
    logic               keep;
    hlc_mark_t          mark;
    logic               act_bypass;
    logic [COORD_W-1:0] act_width_m1;
    logic [COORD_W-1:0] act_height_m1;
    logic [COORD_W-1:0] act_left;
    logic [COORD_W-1:0] act_right;

    hlc_ctrl_fsm i_fsm (
        .clk        (clk),
        .rst        (rst),
        .frame_done (frame_done),
        .stream_en  (stream_en),
        .load_en    (load_en)
    );

    hlc_shadow_cfg #(.COORD_W(COORD_W)) i_shadow (
        .clk           (clk),
        .rst           (rst),
        .load_en       (load_en),
        .reload_dis    (cfg_reload_dis),
        .bypass_in     (cfg_bypass),
        .size_in       (cfg_size),
        .clip_in       (cfg_clip),
        .act_bypass    (act_bypass),
        .act_width_m1  (act_width_m1),
        .act_height_m1 (act_height_m1),
        .act_left      (act_left),
        .act_right     (act_right)
    );

    hlc_col_track #(.COORD_W(COORD_W)) i_track (
        .clk           (clk),
        .rst           (rst),
        .clear         (load_en),
        .fire          (fire),
        .in_sol        (in_sol),
        .in_eof        (in_eof),
        .act_bypass    (act_bypass),
        .act_width_m1  (act_width_m1),
        .act_height_m1 (act_height_m1),
        .act_left      (act_left),
        .act_right     (act_right),
        .keep          (keep),
        .mark          (mark)
    );

    assign in_ready   = stream_en && (out_ready || !keep);
    assign fire       = in_valid && in_ready;
    assign frame_done = fire && in_eof;

    assign out_valid  = stream_en && in_valid && keep;
    assign out_data   = in_data;
    assign out_sol    = mark.first;
    assign out_eol    = mark.last;
    assign out_eof    = mark.last && mark.frame_last;

    // R1: nothing accepted or offered during reset
    p_quiet_in_reset_r1: assert property (@(posedge clk)
        rst |-> (!in_ready && !out_valid));

    // R4: bypass forwards every offered pixel
    p_bypass_forward_r4: assert property (@(posedge clk) disable iff (rst)
        (stream_en && act_bypass && in_valid) |-> out_valid);

    // R9: dropped pixels never stall
    p_drop_no_stall_r9: assert property (@(posedge clk) disable iff (rst)
        (stream_en && in_valid && !out_valid) |-> in_ready);

    // R9: kept pixels follow downstream back-pressure
    p_kept_backpressure_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (in_ready == out_ready));

endmodule

// File: tb/test_hline_clip.sv
`timescale 1ns/1ps
module test_hline_clip;

    localparam int PIX_W   = 24;
    localparam int COORD_W = 16;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 cfg_bypass = 1'b1;
    logic                 cfg_reload_dis = 1'b0;
    logic [2*COORD_W-1:0] cfg_size = '0;
    logic [2*COORD_W-1:0] cfg_clip = '0;
    logic                 in_valid = 1'b0;
    logic                 in_ready;
    logic [PIX_W-1:0]     in_data = '0;
    logic                 in_sol = 1'b0;
    logic                 in_eof = 1'b0;
    logic                 out_valid;
    logic                 out_ready = 1'b0;
    logic [PIX_W-1:0]     out_data;
    logic                 out_sol;
    logic                 out_eol;
    logic                 out_eof;

    always #2.5 clk = ~clk;

    hline_clip #(.PIX_W(PIX_W), .COORD_W(COORD_W)) i_hline_clip (
        .clk(clk), .rst(rst),
        .cfg_bypass(cfg_bypass), .cfg_reload_dis(cfg_reload_dis),
        .cfg_size(cfg_size), .cfg_clip(cfg_clip),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sol(in_sol), .in_eof(in_eof),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sol(out_sol), .out_eol(out_eol), .out_eof(out_eof)
    );

    int checks = 0;
    int errors = 0;
    int frame_no = 0;

    // model of the active configuration
    int mW = 1, mH = 1, mx = 0, mw = 1;
    bit mbp = 1'b1;

    logic [PIX_W+2:0] exp_q[$];
    string            tag_q[$];

    function automatic logic [PIX_W-1:0] pix_val(int l, int c, int f);
        return {8'(l), 8'(c), 8'(f)};
    endfunction

    function automatic bit in_window(int c);
        return mbp || (c >= mx && c < mx + mw);
    endfunction

    // output monitor and back-pressure generator
    always @(posedge clk) begin
        #1;
        out_ready = ($urandom % 4) != 0;
        #3;
        if (!rst && out_valid) begin
            checks++;
            if (in_ready !== out_ready) begin
                errors++;
                $display("FAIL R9 in_ready got %b exp %b", in_ready, out_ready);
            end
            if (out_ready) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R2 unexpected pixel got %h exp none", out_data);
                end else begin
                    logic [PIX_W+2:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    checks++;
                    if (out_data !== e[PIX_W+2:3]) begin
                        errors++;
                        $display("FAIL %s data got %h exp %h", t, out_data, e[PIX_W+2:3]);
                    end
                    checks++;
                    if ({out_sol, out_eol} !== e[2:1]) begin
                        errors++;
                        $display("FAIL R5 sol/eol got %b exp %b", {out_sol, out_eol}, e[2:1]);
                    end
                    checks++;
                    if (out_eof !== e[0]) begin
                        errors++;
                        $display("FAIL R6 eof got %b exp %b", out_eof, e[0]);
                    end
                end
            end
        end
    end

    task automatic send_px(input logic [PIX_W-1:0] d, input bit sol, input bit eof, input bit blk);
        in_valid = 1'b1;
        in_data  = d;
        in_sol   = sol;
        in_eof   = eof;
        if (blk) begin
            #1.5;
            checks++;
            if (in_ready !== 1'b0) begin
                errors++;
                $display("FAIL R10 boundary in_ready got %b exp 0", in_ready);
            end
            @(negedge clk);
        end
        forever begin
            #1.5;
            if (in_ready) begin
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic run_frame(input int W, input int H, input int x, input int w,
                             input bit rdis, input bit scram, input bit junk, input string tag);
        bit bp;
        bit first;
        bp = (w == W);
        cfg_bypass     = bp;
        cfg_reload_dis = rdis;
        cfg_size       = {16'(W - 1), 16'(H - 1)};
        if (bp) cfg_clip = junk ? {16'd5, 16'd3} : '0;
        else    cfg_clip = {16'(x), 16'(W - (x + w) - 1)};
        if (!rdis) begin
            mW = W; mH = H; mx = x; mw = w; mbp = bp;
        end
        frame_no++;
        for (int l = 0; l < mH; l++) begin
            for (int c = 0; c < mW; c++) begin
                if (in_window(c)) begin
                    bit s, e;
                    s = mbp ? (c == 0) : (c == mx);
                    e = mbp ? (c == mW - 1) : (c == mx + mw - 1);
                    exp_q.push_back({pix_val(l, c, frame_no), s, e, e && (l == mH - 1)});
                    tag_q.push_back(tag);
                end
            end
        end
        first = 1'b1;
        for (int l = 0; l < mH; l++) begin
            for (int c = 0; c < mW; c++) begin
                if (!first && ($urandom % 5) == 0) begin
                    in_valid = 1'b0;
                    @(negedge clk);
                end
                send_px(pix_val(l, c, frame_no), c == 0, (l == mH - 1) && (c == mW - 1), first);
                first = 1'b0;
                if (scram && l == 0 && c == mW - 1) begin
                    cfg_bypass = 1'b1;
                    cfg_clip   = '0;
                    cfg_size   = 32'h0003_0002;
                end
            end
        end
        in_valid = 1'b0;
        in_sol   = 1'b0;
        in_eof   = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog all requirements got hang exp completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_C11F);
        cfg_size = {16'd9, 16'd2};
        cfg_clip = {16'd2, 16'd2};
        cfg_bypass = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            checks++;
            if (in_ready !== 1'b0 || out_valid !== 1'b0) begin
                errors++;
                $display("FAIL R1 reset ready/valid got %b%b exp 00", in_ready, out_valid);
            end
        end
        rst = 1'b0;
        // R2: inner window, right count 2
        run_frame(10, 3, 2, 5, 0, 0, 0, "R2");
        // R2: window at column 0
        run_frame(9, 2, 0, 4, 0, 0, 0, "R2");
        // R3: window reaches last column, right count all ones
        run_frame(8, 2, 3, 5, 0, 0, 0, "R3");
        // R3: single column window
        run_frame(7, 3, 4, 1, 0, 0, 0, "R3");
        // R4: bypass with nonzero clip word
        run_frame(6, 2, 0, 6, 0, 0, 1, "R4");
        // R4: one pixel frame
        run_frame(1, 1, 0, 1, 0, 0, 0, "R4");
        run_frame(12, 3, 3, 6, 0, 0, 0, "R2");
        // R8: reload disabled, previous geometry stays
        run_frame(5, 2, 1, 2, 1, 0, 0, "R8");
        // R7: configuration scrambled mid-frame
        run_frame(11, 3, 1, 7, 0, 1, 0, "R7");
        run_frame(11, 2, 2, 3, 0, 0, 0, "R7");
        for (int i = 0; i < 30; i++) begin
            int W, H, x, w;
            W = 1 + int'($urandom % 24);
            w = 1 + int'($urandom % W);
            x = int'($urandom % (W - w + 1));
            H = 1 + int'($urandom % 4);
            if (w == W) x = 0;
            run_frame(W, H, x, w, 0, 0, 0, (w == W) ? "R4" : "R2");
        end
        repeat (80) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R6 missing pixels got %0d left exp 0", exp_q.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule